// File: doc/BRIEF.md
# Performance Level Transition Controller

This block sets the operating point of a processor subsystem that has its own supply regulator. Software asks for one of eight levels with a 3-bit code. Each level stands for a fixed pairing of clock frequency and supply voltage. The block then moves the subsystem to that level in an order that keeps the clock from outrunning the supply. When the subsystem runs faster, the regulator is raised and allowed to settle before the clock divider changes. When it runs slower, the clock divider drops first and the regulator is lowered afterwards.

The regulator is set by one write of an 8-bit value to an 8-bit register address. This write goes to a serial-bus master through a request/acknowledge pair. After each write, a settle timer counts a programmable number of clock cycles. The requester uses a four-phase handshake: it holds `lvl_req` and the code, the block raises `lvl_ack` when the change is complete, and the requester drops `lvl_req` to end the exchange. While a change is in progress, `busy` is high, `cur_level` still shows the old level and `nxt_level` shows the target.

The controller has four states:
- **IDLE** waits for a request.
- **VWRITE** holds a regulator write until the bus acknowledges it.
- **SETTLE** waits for the timer.
- **DONE** holds the acknowledge until the request is withdrawn.

The transitions are:
- IDLE→DONE when the requested level is already active.
- IDLE→VWRITE for any other level. On a downward change the divider is applied on this edge.
- VWRITE→SETTLE on the bus acknowledge.
- SETTLE→DONE when the timer expires. On an upward change the divider is applied on this edge.
- DONE→IDLE when the request is released.

Top module: `perf_level_ctrl`

## Requirements
- R1: After reset, `cur_level`, `nxt_level` and `div_sel` equal RESET_LEVEL (default 0), and `lvl_ack`, `busy` and `bus_req` are low.
- R2: A regulator write carries address REG_ADDR (default 8'h5C) and the data code (V − 0.5 V)/12.5 mV. The levels map as follows: 0 and 1 → 0.950 V (36), 2 → 0.975 V (38), 3 → 1.00 V (40), 4 → 1.05 V (44), 5 → 1.10 V (48), 6 → 1.15 V (52), 7 → 1.20 V (56). A higher code is never a lower voltage.
- R3: On an upward change (target code above current), `bus_req` rises one cycle after the request is accepted. `div_sel` keeps its old value until the write has been acknowledged and the settle time has run.
- R4: On a downward change, `div_sel` takes the target code one cycle after the request is accepted. This is the same cycle in which `bus_req` first rises, so the divider change comes before the write completes.
- R5: Let the write be acknowledged at clock edge n. The next step comes at edge n + `settle_cycles` + 1. On an upward change that step is the `div_sel` update. On a downward change it is the rise of `lvl_ack`.
- R6: `bus_req` stays high, with `bus_addr` and `bus_data` stable, until `bus_ack` is seen. Exactly one write is made per change of level.
- R7: A request for the already active level raises `lvl_ack` within 2 cycles and makes no bus write.
- R8: `lvl_ack` rises when the change completes and stays high until `lvl_req` falls. It is low one cycle after `lvl_req` falls. `cur_level` takes the target value at the edge where `lvl_ack` rises, and at no other time.
- R9: During a change, `busy` is high and `nxt_level` shows the target. When idle, `nxt_level` equals `cur_level`.
- R10: A change of `lvl_code` during a transition is held off. `lvl_ack` stays low, the target does not change, and the transition finishes at the originally requested level.
- R11: The voltage code of the level in `div_sel` never exceeds the last voltage code written to the regulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 1 | Level change request, held until acknowledged |
| lvl_code | input | 3 | Requested level code |
| settle_cycles | input | SETTLE_W | Regulator settle time in clock cycles |
| lvl_ack | output | 1 | Level change complete |
| busy | output | 1 | Transition in progress |
| cur_level | output | 3 | Level currently in effect |
| nxt_level | output | 3 | Target level of the present or last change |
| div_sel | output | 3 | Clock divider selection (level code whose frequency is applied) |
| bus_req | output | 1 | Regulator write request to the serial-bus master |
| bus_addr | output | 8 | Regulator register address |
| bus_data | output | 8 | Regulator voltage code |
| bus_ack | input | 1 | Write accepted by the serial-bus master |

## Verification
Each fault in the controller's state shows at the ports within a few cycles of the transition it disturbs:
- A wrong direction flag shows as `div_sel` moving in the wrong cycle relative to `bus_req`.
- A stale target shows as a wrong `bus_data` code during the write, or a wrong `cur_level` at acknowledge.
- A timer off by one moves the divider or the acknowledge by a cycle against the measured acknowledge edge.

Every ordered pair of levels is swept, with varied settle times and bus latencies, so each of these faults is seen at some port timing.

// File: rtl/pl_pkg.sv
package pl_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 1 << LVL_W;
    localparam int BUS_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VWRITE,
        ST_SETTLE,
        ST_DONE
    } pl_state_t;

    // Regulator code for a level: (V - 500 mV) / 12.5 mV.
    function automatic logic [BUS_W-1:0] lvl_vcode(input logic [LVL_W-1:0] lvl);
        int mv;
        unique case (lvl)
            3'd0, 3'd1: mv = 950;
            3'd2:       mv = 975;
            default:    mv = 1000 + 50 * (int'(lvl) - 3);
        endcase
        return BUS_W'(((mv - 500) * 2) / 25);
    endfunction

endpackage

// File: rtl/pl_vtable.sv
module pl_vtable
    import pl_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    output logic [BUS_W-1:0] vcode
);

    always_comb vcode = lvl_vcode(lvl);

endmodule

// File: rtl/pl_settle_timer.sv
module pl_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pl_fsm.sv
module pl_fsm
    import pl_pkg::*;
#(
    parameter logic [LVL_W-1:0] RESET_LEVEL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_req,
    input  logic [LVL_W-1:0] lvl_code,
    input  logic             bus_ack,
    input  logic             settle_done,
    output logic             lvl_ack,
    output logic             busy,
    output logic             bus_req,
    output logic             timer_load,
    output logic [LVL_W-1:0] cur_level,
    output logic [LVL_W-1:0] tgt_level,
    output logic [LVL_W-1:0] div_sel
);

    pl_state_t        state_q, state_d;
    logic [LVL_W-1:0] cur_q, tgt_q, div_q;
    logic             up_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lvl_req) begin
                    if (lvl_code == cur_q) state_d = ST_DONE;
                    else                   state_d = ST_VWRITE;
                end
            end
            ST_VWRITE: if (bus_ack)     state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_DONE;
            ST_DONE:   if (!lvl_req)    state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        lvl_ack    = 1'b0;
        busy       = 1'b0;
        bus_req    = 1'b0;
        timer_load = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VWRITE: begin
                busy       = 1'b1;
                bus_req    = 1'b1;
                timer_load = bus_ack;
            end
            ST_SETTLE: busy    = 1'b1;
            ST_DONE:   lvl_ack = 1'b1;
        endcase
    end

    // Level bookkeeping: target capture, divider and current level updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= RESET_LEVEL;
            tgt_q <= RESET_LEVEL;
            div_q <= RESET_LEVEL;
            up_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && lvl_req) begin
                tgt_q <= lvl_code;
                up_q  <= (lvl_code > cur_q);
                // Slowing down: the divider leads the voltage
                if (lvl_code < cur_q) div_q <= lvl_code;
            end
            if (state_q == ST_SETTLE && settle_done) begin
                cur_q <= tgt_q;
                // Speeding up: the divider trails the settled voltage
                if (up_q) div_q <= tgt_q;
            end
        end
    end

    assign cur_level = cur_q;
    assign tgt_level = tgt_q;
    assign div_sel   = div_q;

endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl
    import pl_pkg::*;
#(
    parameter int                SETTLE_W    = 8,
    parameter logic [BUS_W-1:0]  REG_ADDR    = 8'h5C,
    parameter logic [LVL_W-1:0]  RESET_LEVEL = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lvl_req,
    input  logic [LVL_W-1:0]    lvl_code,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                lvl_ack,
    output logic                busy,
    output logic [LVL_W-1:0]    cur_level,
    output logic [LVL_W-1:0]    nxt_level,
    output logic [LVL_W-1:0]    div_sel,
    output logic                bus_req,
    output logic [BUS_W-1:0]    bus_addr,
    output logic [BUS_W-1:0]    bus_data,
    input  logic                bus_ack
);

    logic             timer_load;
    logic             settle_done;
    logic [LVL_W-1:0] tgt_level;

    pl_fsm #(
        .RESET_LEVEL(RESET_LEVEL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_req    (lvl_req),
        .lvl_code   (lvl_code),
        .bus_ack    (bus_ack),
        .settle_done(settle_done),
        .lvl_ack    (lvl_ack),
        .busy       (busy),
        .bus_req    (bus_req),
        .timer_load (timer_load),
        .cur_level  (cur_level),
        .tgt_level  (tgt_level),
        .div_sel    (div_sel)
    );

    pl_settle_timer #(
        .W(SETTLE_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (timer_load),
        .load_val(settle_cycles),
        .expired (settle_done)
    );

    pl_vtable u_vtable (
        .lvl  (tgt_level),
        .vcode(bus_data)
    );

    assign bus_addr  = REG_ADDR;
    assign nxt_level = tgt_level;

endmodule

// File: rtl/pl_ctrl_chk.sv
module pl_ctrl_chk
    import pl_pkg::*;
#(
    parameter logic [LVL_W-1:0] RESET_LEVEL = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lvl_req,
    input logic [LVL_W-1:0] lvl_code,
    input logic             lvl_ack,
    input logic             busy,
    input logic [LVL_W-1:0] cur_level,
    input logic [LVL_W-1:0] nxt_level,
    input logic [LVL_W-1:0] div_sel,
    input logic             bus_req,
    input logic [BUS_W-1:0] bus_addr,
    input logic [BUS_W-1:0] bus_data,
    input logic             bus_ack
);

    logic [BUS_W-1:0] volt_q;

    // Last voltage code accepted by the regulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  volt_q <= lvl_vcode(RESET_LEVEL);
        else if (bus_req && bus_ack) volt_q <= bus_data;
    end

    p_bus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_data) && $stable(bus_addr)));

    p_same_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !lvl_ack && lvl_req && lvl_code == cur_level) |=> (lvl_ack && !bus_req));

    p_ack_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_ack |-> (cur_level == nxt_level && !busy && !bus_req));

    p_cur_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_level) |-> $rose(lvl_ack));

    p_hold_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(nxt_level));

    p_freq_le_volt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_vcode(div_sel) <= volt_q);

endmodule

bind perf_level_ctrl pl_ctrl_chk #(
    .RESET_LEVEL(RESET_LEVEL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_req  (lvl_req),
    .lvl_code (lvl_code),
    .lvl_ack  (lvl_ack),
    .busy     (busy),
    .cur_level(cur_level),
    .nxt_level(nxt_level),
    .div_sel  (div_sel),
    .bus_req  (bus_req),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_ack  (bus_ack)
);

// File: tb/perf_level_ctrl_tb.sv
module perf_level_ctrl_tb;

    localparam logic [7:0] ADDR = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lvl_req = 1'b0;
    logic [2:0] lvl_code = 3'd0;
    logic [7:0] settle_cycles = 8'd0;
    logic       lvl_ack, busy, bus_req, bus_ack;
    logic [2:0] cur_level, nxt_level, div_sel;
    logic [7:0] bus_addr, bus_data;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    // Bus stub state
    int   stub_dly = 0;
    int   stub_wait = 0;
    int   wcount = 0;
    int   ack_set_cyc = 0;
    logic [7:0] w_data = '0;
    logic [7:0] w_addr = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    perf_level_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .lvl_code(lvl_code),
        .settle_cycles(settle_cycles), .lvl_ack(lvl_ack), .busy(busy),
        .cur_level(cur_level), .nxt_level(nxt_level), .div_sel(div_sel),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_ack(bus_ack)
    );

    initial bus_ack = 1'b0;

    // Serial-bus master stub: acknowledges after stub_dly waiting cycles
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (stub_wait >= stub_dly) begin
                bus_ack     = 1'b1;
                wcount      = wcount + 1;
                w_data      = bus_data;
                w_addr      = bus_addr;
                ack_set_cyc = cyc;
                stub_wait   = 0;
            end else begin
                stub_wait = stub_wait + 1;
            end
        end
    end

    function automatic int exp_vcode(input int lvl);
        int mv;
        if (lvl <= 1)      mv = 950;
        else if (lvl == 2) mv = 975;
        else               mv = 1000 + 50 * (lvl - 3);
        return ((mv - 500) * 2) / 25;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Level change; flip >= 0 changes lvl_code mid-transition (hold-off test)
    task automatic change(input int to, input int settle, input int flip);
        int from, c0, w0, first_req, div_chg, ack_c, guard, n_busy;
        logic [2:0] div_prev;
        bit tgt_ok;
        @(negedge clk);
        settle_cycles = 8'(settle);
        lvl_code = 3'(to);
        lvl_req  = 1'b1;
        from = int'(cur_level);
        c0 = cyc; w0 = wcount;
        first_req = -1; div_chg = -1; guard = 0; n_busy = 0; tgt_ok = 1'b1;
        div_prev = div_sel;
        forever begin
            @(negedge clk);
            guard++;
            if (bus_req && first_req < 0) first_req = cyc;
            if (div_sel != div_prev && div_chg < 0) div_chg = cyc;
            if (busy) begin
                n_busy++;
                if (nxt_level != 3'(to)) tgt_ok = 1'b0;
                if (flip >= 0 && n_busy == 2) lvl_code = 3'(flip);
            end
            if (lvl_ack || guard > 2000) break;
        end
        ack_c = cyc;
        if (guard > 2000) chk(1'b0, "watchdog", guard, 2000);
        chk(cur_level == 3'(to), "R8 cur_level at ack", int'(cur_level), to);
        chk(div_sel == 3'(to), "R3/R4 div_sel final", int'(div_sel), to);
        chk(tgt_ok, "R9/R10 nxt_level held at target while busy", int'(tgt_ok), 1);
        if (to == from) begin
            chk(ack_c - c0 <= 2, "R7 ack latency", ack_c - c0, 2);
            chk(wcount == w0, "R7 no bus write", wcount - w0, 0);
        end else begin
            chk(wcount - w0 == 1, "R6 one write per change", wcount - w0, 1);
            chk(int'(w_data) == exp_vcode(to), "R2 voltage code", int'(w_data), exp_vcode(to));
            chk(w_addr == ADDR, "R2 regulator address", int'(w_addr), int'(ADDR));
            chk(first_req == c0 + 1, "R3/R4 write issue cycle", first_req, c0 + 1);
            if (to > from) begin
                chk(div_chg == ack_set_cyc + settle + 2, "R3 R5 divider after settle",
                    div_chg, ack_set_cyc + settle + 2);
            end else begin
                chk(div_chg == c0 + 1, "R4 divider before write", div_chg, c0 + 1);
                chk(ack_c == ack_set_cyc + settle + 2, "R5 ack after settle",
                    ack_c, ack_set_cyc + settle + 2);
            end
            chk(n_busy > 0, "R9 busy during change", n_busy, 1);
        end
        lvl_req = 1'b0;
        @(negedge clk);
        chk(!lvl_ack && !busy, "R8 ack release", int'(lvl_ack), 0);
        chk(nxt_level == cur_level, "R9 idle status", int'(nxt_level), int'(cur_level));
    endtask

    // Global watchdog
    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cur_level == 3'd0 && nxt_level == 3'd0, "R1 reset levels", int'(cur_level), 0);
        chk(div_sel == 3'd0, "R1 reset divider", int'(div_sel), 0);
        chk(!lvl_ack && !busy && !bus_req, "R1 reset controls", int'(bus_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Exhaustive sweep over all ordered level pairs
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 8; t++) begin
                stub_dly = (f + 2 * t) % 4;
                change(f, (f * 3 + t) % 5, -1);
                stub_dly = (t + 1) % 3;
                change(t, (f * 5 + t * 3) % 6, -1);
            end
        end
        // R10 hold-off: code flips mid-transition, upward and downward
        stub_dly = 2;
        change(0, 1, -1);
        change(7, 10, 3);
        change(1, 9, 6);
        change(1, 0, -1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule